// File: doc/BRIEF.md
# Pin-change interrupt detector for a six-line input port

This block watches a small general-purpose input port and reports when any pin that software has armed no longer matches a snapshot of the port. The snapshot is not the previous clock's sample. It is the value the pins had at the last software access to the port, either a read or a write. Until software touches the port again, a changed pin keeps the interrupt condition alive, so the pending flag cannot be cleared while a difference remains.

Software reaches the block through a small register bus. The bus has three locations: the port, the per-pin arm register and the pending flag.

- The pins pass through a two-flop synchroniser before they are compared.
- The flag drives two outputs. The interrupt request goes high only when the global interrupt enable is set. The wake request goes high while the sleep input is high.
- A crystal-oscillator mode input takes arm bits 5 and 4 out of use.
- While the wake-up-reset feature is on and the device sleeps, arm bit 3 is ignored.
- The snapshot and the arm register are cleared only by the power-on reset.
- The system reset (master clear or brown-out) clears only the flag.

The flag is held by a two-state machine:

- `ST_QUIET`: no event is pending. Transition *raise*: a mismatch moves it to `ST_PEND`.
- `ST_PEND`: the flag is set. Transition *release*: a write of 0 to the flag while no mismatch is present moves it back to `ST_QUIET`. Transition *hold*: any other cycle keeps it in `ST_PEND`.
- A system reset sends it to `ST_QUIET`.

Top module: `pin_change_irq`

## Requirements
- R1: The arm register at bus address 1 keeps bits 5:0 of the written data. Bit n = 1 arms pin n; bit n = 0 disarms it.
- R2: Reading address 1 always returns 0 in bits 7:6.
- R3: Power-on reset clears the arm register, the snapshot and the flag. After it, the flag, irq_o and wake_o are 0.
- R4: When an armed pin differs from the snapshot, the flag rises. This happens on the third rising edge after the pin changes, because two of those edges are the synchroniser.
- R5: A bus read or write of address 0 loads the snapshot with the synchronised pins, and this ends the mismatch. A write of 0 in data bit 0 to address 2 clears the flag only when no mismatch is present; otherwise the flag stays 1.
- R6: Writing 1 in data bit 0 to address 2 never sets the flag.
- R7: A system reset clears the flag but leaves the snapshot and the arm register intact. In the first cycle after the reset is released, the flag is set again if a mismatch is present.
- R8: irq_o equals flag AND gie_i. wake_o equals flag AND sleep_i.
- R9: While xtal_i is 1, arm bits 5 and 4 read as 0 at address 1, and changes on pins 5 and 4 are not detected.
- R10: While wur_en_i and sleep_i are both 1, pin 3 is not detected.
- R11: A pin change that lands in the same cycle as a port access may be absorbed into the snapshot. Afterwards, a port access followed by a clear always leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| sys_rst_n | input | 1 | Master-clear / brown-out reset, active low |
| pin_i | input | 6 | Asynchronous port pins |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 port, 1 arm register, 2 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| gie_i | input | 1 | Global interrupt enable |
| xtal_i | input | 1 | Crystal oscillator mode |
| sleep_i | input | 1 | Device asleep |
| wur_en_i | input | 1 | Wake-up-reset feature enabled |
| flag_o | output | 1 | Pending change flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The hardest situation to reach from the ports is a flag that survives a system reset. It needs a snapshot that differs from the pins while the flag itself is forced to 0. The stimulus builds this in three steps:

1. Take a snapshot with a port read.
2. Move a pin and let the flag rise.
3. Pulse only sys_rst_n.

It then checks that the flag is 0 during the reset, returns one cycle after release, and that the arm register reads back unchanged. The sticky clear is also driven both ways: a clear without a port access must leave the flag set, and a clear after one must drop it.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    typedef enum logic [1:0] {
        A_PORT = 2'd0,
        A_ARM  = 2'd1,
        A_FLAG = 2'd2,
        A_NONE = 2'd3
    } addr_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_PEND  = 1'b1
    } flag_st_e;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/pcd_arm.sv
module pcd_arm #(
    parameter int W       = 6,
    parameter int XTAL_LO = 4,
    parameter int XTAL_HI = 5,
    parameter int WUR_BIT = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         xtal_i,
    input  logic         sleep_i,
    input  logic         wur_en_i,
    output logic [W-1:0] arm_rd_o,
    output logic [W-1:0] arm_eff_o
);
    logic [W-1:0] arm_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) arm_q <= '0;
        else if (wr_i) arm_q <= wdata_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i >= XTAL_LO && i <= XTAL_HI) begin : g_xtal
            assign arm_rd_o[i] = arm_q[i] & ~xtal_i;
        end else begin : g_plain
            assign arm_rd_o[i] = arm_q[i];
        end
        if (i == WUR_BIT) begin : g_wur
            assign arm_eff_o[i] = arm_rd_o[i] & ~(wur_en_i & sleep_i);
        end else begin : g_norm
            assign arm_eff_o[i] = arm_rd_o[i];
        end
    end

    // R9: in crystal mode, the oscillator-pin arm bits read back as 0
    p_xtal_read_r9: assert property (@(posedge clk) disable iff (!por_n)
        xtal_i |-> (arm_rd_o[XTAL_HI:XTAL_LO] == '0));
endmodule

// File: rtl/pcd_snapshot.sv
module pcd_snapshot #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         acc_i,
    input  logic [W-1:0] pin_s_i,
    input  logic [W-1:0] arm_eff_i,
    output logic         mismatch_o
);
    logic [W-1:0] snap_q;
    logic [W-1:0] snap_now;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) snap_q <= '0;
        else if (acc_i) snap_q <= pin_s_i;
    end

    assign snap_now   = acc_i ? pin_s_i : snap_q;
    assign mismatch_o = |((pin_s_i ^ snap_now) & arm_eff_i);

    // R5: the snapshot only moves on a port access
    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        !acc_i |=> $stable(snap_q));
endmodule

// File: rtl/pcd_flag_fsm.sv
module pcd_flag_fsm
    import pcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch_i,
    input  logic clr_i,
    input  logic gie_i,
    input  logic sleep_i,
    output logic flag_o,
    output logic irq_o,
    output logic wake_o
);
    flag_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (mismatch_i) st_d = ST_PEND;          // raise
            ST_PEND:  if (clr_i && !mismatch_i) st_d = ST_QUIET; // release, else hold
            default:  st_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        flag_o = (st_q == ST_PEND);
        irq_o  = flag_o & gie_i;
        wake_o = flag_o & sleep_i;
    end

    // R4: any mismatch sets the flag on the next edge
    p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_i |=> flag_o);
    // R5: a clear under a live mismatch does not drop the flag
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_i && mismatch_i) |=> flag_o);
    // R6: with no mismatch, nothing else sets the flag
    p_no_self_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !mismatch_i) |=> !flag_o);
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcd_pkg::*;
#(
    parameter int W       = 6,
    parameter int DATA_W  = 8,
    parameter int XTAL_LO = 4,
    parameter int XTAL_HI = 5,
    parameter int WUR_BIT = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [W-1:0]      pin_i,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie_i,
    input  logic              xtal_i,
    input  logic              sleep_i,
    input  logic              wur_en_i,
    output logic              flag_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int PAD = DATA_W - W;

    addr_e        addr;
    logic [W-1:0] pin_s, arm_rd, arm_eff;
    logic         port_acc, arm_wr, clr, mismatch, flag_rst_n;
    logic         unused_wdata;

    assign addr         = addr_e'(bus_addr);
    assign port_acc     = (bus_rd | bus_wr) && addr == A_PORT;
    assign arm_wr       = bus_wr && addr == A_ARM;
    assign clr          = bus_wr && addr == A_FLAG && !bus_wdata[0];
    assign flag_rst_n   = por_n & sys_rst_n;
    assign unused_wdata = ^bus_wdata[DATA_W-1:W];

    pcd_sync #(.W(W)) u_sync (
        .clk(clk), .por_n(por_n), .d_i(pin_i), .q_o(pin_s)
    );

    pcd_arm #(.W(W), .XTAL_LO(XTAL_LO), .XTAL_HI(XTAL_HI), .WUR_BIT(WUR_BIT)) u_arm (
        .clk(clk), .por_n(por_n), .wr_i(arm_wr), .wdata_i(bus_wdata[W-1:0]),
        .xtal_i(xtal_i), .sleep_i(sleep_i), .wur_en_i(wur_en_i),
        .arm_rd_o(arm_rd), .arm_eff_o(arm_eff)
    );

    pcd_snapshot #(.W(W)) u_snap (
        .clk(clk), .por_n(por_n), .acc_i(port_acc), .pin_s_i(pin_s),
        .arm_eff_i(arm_eff), .mismatch_o(mismatch)
    );

    pcd_flag_fsm u_fsm (
        .clk(clk), .rst_n(flag_rst_n), .mismatch_i(mismatch), .clr_i(clr),
        .gie_i(gie_i), .sleep_i(sleep_i),
        .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    always_comb begin
        unique case (addr)
            A_PORT:  bus_rdata = {{PAD{1'b0}}, pin_s};
            A_ARM:   bus_rdata = {{PAD{1'b0}}, arm_rd};
            A_FLAG:  bus_rdata = {{(DATA_W-1){1'b0}}, flag_o};
            default: bus_rdata = '0;
        endcase
    end

    // R2: unimplemented arm bits read as 0
    p_arm_top_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && addr == A_ARM) |-> (bus_rdata[DATA_W-1:W] == '0));
    // R8: no interrupt request without the global enable
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!flag_rst_n)
        irq_o |-> (gie_i && flag_o));
endmodule

// File: tb/tb_pin_change_irq.sv
`timescale 1ns/100ps
module tb_pin_change_irq;
    logic       clk = 0;
    logic       por_n = 0, sys_rst_n = 1;
    logic [5:0] pin = 0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       gie = 0, xtal = 0, sleep = 0, wur = 0;
    logic       flag, irq, wake;
    int         checks = 0, errors = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    pin_change_irq dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .pin_i(pin),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gie_i(gie), .xtal_i(xtal), .sleep_i(sleep), .wur_en_i(wur),
        .flag_o(flag), .irq_o(irq), .wake_o(wake)
    );

    // {arm, pins at snapshot, new pins, expected flag}
    localparam logic [0:7][18:0] VEC = {
        {6'h3F, 6'h00, 6'h01, 1'b1},
        {6'h3F, 6'h15, 6'h15, 1'b0},
        {6'h01, 6'h00, 6'h02, 1'b0},
        {6'h02, 6'h00, 6'h02, 1'b1},
        {6'h20, 6'h3F, 6'h1F, 1'b1},
        {6'h00, 6'h3F, 6'h00, 1'b0},
        {6'h0C, 6'h0A, 6'h06, 1'b1},
        {6'h30, 6'h0F, 6'h03, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        ticks(1);
        bus_wr = 0; bus_addr = 2'd3; bus_wdata = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        ticks(1);
        bus_rd = 0; bus_addr = 2'd3;
    endtask

    task automatic snap_and_clear();
        logic [7:0] tmp;
        bus_read(2'd0, tmp);
        bus_write(2'd2, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bus_addr = 2'd3;
        ticks(3);
        chk("R3 flag after por", {7'b0, flag}, 8'h00);
        chk("R3 irq/wake after por", {6'b0, irq, wake}, 8'h00);
        por_n = 1;
        ticks(1);
        bus_read(2'd1, rd);
        chk("R3 arm after por", rd, 8'h00);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, rd);
        chk("R1 R2 arm readback", rd, 8'h3F);

        // vector table walk
        for (int i = 0; i < 8; i++) begin
            bus_write(2'd1, {2'b0, VEC[i][18:13]});
            pin = VEC[i][12:7];
            ticks(3);
            snap_and_clear();
            chk("R4 flag clear before change", {7'b0, flag}, 8'h00);
            pin = VEC[i][6:1];
            ticks(4);
            chk($sformatf("R1 R4 vector %0d", i), {7'b0, flag}, {7'b0, VEC[i][0]});
        end

        // R5 sticky clear and port access
        bus_write(2'd1, 8'h3F);
        pin = 6'h00; ticks(3);
        snap_and_clear();
        pin = 6'h01; ticks(4);
        chk("R4 flag on change", {7'b0, flag}, 8'h01);
        bus_write(2'd2, 8'h00);
        ticks(1);
        chk("R5 clear under mismatch keeps flag", {7'b0, flag}, 8'h01);
        bus_read(2'd0, rd);
        chk("R5 port read value", rd, 8'h01);
        bus_write(2'd2, 8'h00);
        chk("R5 clear after read", {7'b0, flag}, 8'h00);
        pin = 6'h00; ticks(4);
        chk("R5 flag re-raised", {7'b0, flag}, 8'h01);
        bus_write(2'd0, 8'h3F);
        bus_write(2'd2, 8'h00);
        chk("R5 clear after port write", {7'b0, flag}, 8'h00);

        // R6 write of 1 has no effect
        bus_write(2'd2, 8'h01);
        ticks(1);
        chk("R6 write 1 does not set", {7'b0, flag}, 8'h00);

        // R7 system reset keeps snapshot and arm
        pin = 6'h04; ticks(4);
        chk("R7 flag before sys reset", {7'b0, flag}, 8'h01);
        sys_rst_n = 0; #1;
        chk("R7 flag cleared in sys reset", {7'b0, flag}, 8'h00);
        ticks(2);
        sys_rst_n = 1;
        ticks(1);
        chk("R7 flag back after sys reset", {7'b0, flag}, 8'h01);
        bus_read(2'd1, rd);
        chk("R7 arm survives sys reset", rd, 8'h3F);

        // R8 irq and wake gating (flag is 1)
        gie = 0; #1;
        chk("R8 irq off without gie", {7'b0, irq}, 8'h00);
        gie = 1; #1;
        chk("R8 irq with gie", {7'b0, irq}, 8'h01);
        sleep = 0; #1;
        chk("R8 no wake awake", {7'b0, wake}, 8'h00);
        sleep = 1; #1;
        chk("R8 wake asleep", {7'b0, wake}, 8'h01);
        @(negedge clk);
        snap_and_clear();
        chk("R8 wake drops with flag", {6'b0, irq, wake}, 8'h00);
        sleep = 0; gie = 0;

        // R9 crystal mode
        xtal = 1; ticks(1);
        bus_read(2'd1, rd);
        chk("R9 arm bits 5:4 read 0", rd, 8'h0F);
        pin = 6'h24; ticks(4);
        chk("R9 pin 5 ignored", {7'b0, flag}, 8'h00);
        xtal = 0; ticks(1);
        chk("R9 pin 5 seen after mode off", {7'b0, flag}, 8'h01);
        snap_and_clear();

        // R10 wake-up-reset while asleep
        wur = 1; sleep = 1; ticks(1);
        pin = 6'h2C; ticks(4);
        chk("R10 pin 3 ignored asleep", {7'b0, flag}, 8'h00);
        sleep = 0; ticks(1);
        chk("R10 pin 3 seen awake", {7'b0, flag}, 8'h01);
        wur = 0;
        snap_and_clear();

        // R11 change concurrent with port read
        bus_rd = 1; bus_addr = 2'd0;
        pin = 6'h2D;
        ticks(2);
        bus_rd = 0; bus_addr = 2'd3;
        ticks(3);
        checks++;
        if (flag !== 1'b0 && flag !== 1'b1) begin
            errors++;
            $display("FAIL R11 flag unknown: actual %b expected 0 or 1", flag);
        end
        snap_and_clear();
        chk("R11 quiet after access and clear", {7'b0, flag}, 8'h00);

        // R3 power-on reset mid-run
        por_n = 0; ticks(1); por_n = 1; ticks(1);
        bus_read(2'd1, rd);
        chk("R3 arm cleared by por", rd, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule